// File: doc/BRIEF.md
# Phase-Multiplexed Multiport Register File

This block is a wide register file that offers twenty logical read ports and four logical write ports per CPU cycle while touching only five physical read ports on each storage copy. It runs on a fast clock five times the CPU rate. A one-cycle strobe, `cpu_tick`, marks the fast edge that coincides with the CPU clock edge. At that edge all twenty read addresses and the four write requests are captured. In the four fast cycles that follow, each physical read port serves a different logical read port, and each write port takes its turn in its own fast cycle. The fifth fast cycle is spare. The twenty results are published together at the next `cpu_tick` edge.

Storage is replicated into one copy per write port, so each copy needs a single write port. A flip-flop table records, for every register, which copy was written last, and the read path picks its data from that copy. A read that names a register written in the same CPU cycle is served from the captured write data. When several write ports target one register in the same cycle, the highest-numbered port wins. The block contains no handshake: the CPU side issues one request set on every CPU cycle.

Top module: `phased_regfile`

## Requirements
- R1: While reset is asserted and until the first results are published, `rd_valid_o` is 0 and every lane of `rd_data_o` is 0.
- R2: The internal phase count returns to 0 on every `cpu_tick` edge. `cpu_tick` is asserted only in the fifth fast cycle of each CPU cycle, counting the cycles from reset release or from the previous tick.
- R3: The read requests captured at one `cpu_tick` edge appear on `rd_data_o` exactly one CPU cycle later, at the next `cpu_tick` edge. Lane j occupies bits [j*128 +: 128] and the address for lane j is `rd_addr_i[j*AW +: AW]`. A register written in an earlier CPU cycle returns the written value.
- R4: A read of a register that is written in the same CPU cycle returns the new write data.
- R5: A read issued in the CPU cycle right after a write of that register returns the written value.
- R6: When several enabled write ports target one register in the same cycle, the highest-numbered port's data is returned, both by a same-cycle read and by any later read.
- R7: A write port whose `wr_en_i` bit is 0 leaves the register file unchanged, whatever its address and data.
- R8: `rd_data_o` changes only on `cpu_tick` edges.
- R9: `rd_valid_o` rises at the second `cpu_tick` edge after reset and stays high after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, five periods per CPU cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick | input | 1 | High in the fast cycle whose rising edge is the CPU clock edge |
| rd_addr_i | input | NRD*AW | Read addresses, lane j at [j*AW +: AW] |
| wr_en_i | input | NWR | Write enables, one per write port |
| wr_addr_i | input | NWR*AW | Write addresses, port w at [w*AW +: AW] |
| wr_data_i | input | NWR*W | Write data, port w at [w*W +: W] |
| rd_data_o | output | NRD*W | Read results, lane j at [j*W +: W] |
| rd_valid_o | output | 1 | High once results from a full CPU cycle are available |

## Verification
Two paths can act on the same register in one CPU cycle: a same-cycle read bypass and the phase-multiplexed write into the storage copies. In that cycle the bypass must hide the storage update. The bench provokes this by reading a register on all twenty lanes in the very cycle that one port, and then three colliding ports, write it. The result is judged both on the bypassed value and on a later plain read, which must show the same highest-port data and so proves that the live-value table and the storage copies agree with the bypass.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_WIDTH     = 128;
  localparam int RF_DEPTH     = 64;
  localparam int RF_WPORTS    = 4;
  localparam int RF_PHYS_RD   = 5;
  localparam int RF_RD_PHASES = 4;
endpackage

// File: rtl/rf_phase_ctrl.sv
module rf_phase_ctrl #(
  parameter int NPH = 5,
  parameter int PW  = 3
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_tick,
  output logic [PW-1:0] phase_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                       phase_o <= '0;
    else if (cpu_tick)                phase_o <= '0;
    else if (phase_o != PW'(NPH - 1)) phase_o <= phase_o + 1'b1;
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int W     = 128,
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int NPR   = 5
)(
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [W-1:0]     wdata,
  input  logic [NPR*AW-1:0] raddr,
  output logic [NPR*W-1:0] rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar k = 0; k < NPR; k++) begin : g_rd
    assign rdata[k*W +: W] = mem[raddr[k*AW +: AW]];
  end
endmodule

// File: rtl/rf_lvt.sv
module rf_lvt #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int SW    = 2,
  parameter int NPR   = 5
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [SW-1:0]     wsel,
  input  logic [NPR*AW-1:0] raddr,
  output logic [NPR*SW-1:0] rsel
);
  logic [SW-1:0] owner [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) owner[i] <= '0;
    end else if (we) begin
      owner[waddr] <= wsel;
    end
  end

  for (genvar k = 0; k < NPR; k++) begin : g_rd
    assign rsel[k*SW +: SW] = owner[raddr[k*AW +: AW]];
  end
endmodule

// File: rtl/phased_regfile.sv
module phased_regfile
  import rf_pkg::*;
#(
  parameter int W     = RF_WIDTH,
  parameter int DEPTH = RF_DEPTH,
  parameter int NWR   = RF_WPORTS,
  parameter int NPR   = RF_PHYS_RD,
  parameter int NRPH  = RF_RD_PHASES,
  localparam int AW   = $clog2(DEPTH),
  localparam int NRD  = NPR * NRPH,
  localparam int NPH  = NRPH + 1,
  localparam int PW   = $clog2(NPH),
  localparam int SW   = (NWR > 1) ? $clog2(NWR) : 1
)(
  input  logic               clk_fast,
  input  logic               rst_n,
  input  logic               cpu_tick,
  input  logic [NRD*AW-1:0]  rd_addr_i,
  input  logic [NWR-1:0]     wr_en_i,
  input  logic [NWR*AW-1:0]  wr_addr_i,
  input  logic [NWR*W-1:0]   wr_data_i,
  output logic [NRD*W-1:0]   rd_data_o,
  output logic               rd_valid_o
);
  logic [PW-1:0] phase;

  rf_phase_ctrl #(.NPH(NPH), .PW(PW)) u_phase (
    .clk(clk_fast), .rst_n(rst_n), .cpu_tick(cpu_tick), .phase_o(phase)
  );

  // Request capture at the CPU edge
  logic [NRD*AW-1:0] cap_raddr;
  logic [NWR-1:0]    cap_wen;
  logic [NWR*AW-1:0] cap_waddr;
  logic [NWR*W-1:0]  cap_wdata;
  logic              cap_vld;

  always_ff @(posedge clk_fast) begin
    if (!rst_n) begin
      cap_raddr <= '0;
      cap_wen   <= '0;
      cap_waddr <= '0;
      cap_wdata <= '0;
      cap_vld   <= 1'b0;
    end else if (cpu_tick) begin
      cap_raddr <= rd_addr_i;
      cap_wen   <= wr_en_i;
      cap_waddr <= wr_addr_i;
      cap_wdata <= wr_data_i;
      cap_vld   <= 1'b1;
    end
  end

  // Write port w owns fast phase w
  logic [NWR-1:0] bank_we;
  logic           lvt_we;
  logic [AW-1:0]  lvt_waddr;
  logic [SW-1:0]  lvt_wsel;

  for (genvar w = 0; w < NWR; w++) begin : g_wslot
    assign bank_we[w] = cap_wen[w] && (phase == PW'(w));
  end

  always_comb begin
    lvt_we    = |bank_we;
    lvt_waddr = '0;
    lvt_wsel  = '0;
    for (int w = 0; w < NWR; w++) begin
      if (bank_we[w]) begin
        lvt_waddr = cap_waddr[w*AW +: AW];
        lvt_wsel  = SW'(w);
      end
    end
  end

  // Physical read addressing: port k serves lane k*NRPH + phase
  logic              rd_act;
  logic [PW-1:0]     rph;
  logic [NPR*AW-1:0] phys_raddr;

  assign rd_act = (phase < PW'(NRPH));
  assign rph    = rd_act ? phase : '0;

  for (genvar k = 0; k < NPR; k++) begin : g_raddr
    assign phys_raddr[k*AW +: AW] = cap_raddr[(k*NRPH + int'(rph))*AW +: AW];
  end

  logic [NPR*SW-1:0] lvt_rsel;

  rf_lvt #(.DEPTH(DEPTH), .AW(AW), .SW(SW), .NPR(NPR)) u_lvt (
    .clk(clk_fast), .rst_n(rst_n), .we(lvt_we), .waddr(lvt_waddr),
    .wsel(lvt_wsel), .raddr(phys_raddr), .rsel(lvt_rsel)
  );

  logic [NPR*W-1:0] bank_rd [NWR];

  for (genvar w = 0; w < NWR; w++) begin : g_bank
    rf_bank #(.W(W), .DEPTH(DEPTH), .AW(AW), .NPR(NPR)) u_bank (
      .clk(clk_fast), .we(bank_we[w]), .waddr(cap_waddr[w*AW +: AW]),
      .wdata(cap_wdata[w*W +: W]), .raddr(phys_raddr), .rdata(bank_rd[w])
    );
  end

  // Copy selection, then same-cycle bypass (highest port last)
  logic [W-1:0] phys_rd [NPR];

  always_comb begin
    for (int k = 0; k < NPR; k++) begin
      phys_rd[k] = bank_rd[lvt_rsel[k*SW +: SW]][k*W +: W];
      for (int w = 0; w < NWR; w++) begin
        if (cap_wen[w] && (cap_waddr[w*AW +: AW] == phys_raddr[k*AW +: AW]))
          phys_rd[k] = cap_wdata[w*W +: W];
      end
    end
  end

  // Collect lanes during the read phases, publish at the CPU edge
  logic [NRD*W-1:0] res_q;

  always_ff @(posedge clk_fast) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (rd_act) begin
      for (int k = 0; k < NPR; k++)
        res_q[(k*NRPH + int'(rph))*W +: W] <= phys_rd[k];
    end
  end

  always_ff @(posedge clk_fast) begin
    if (!rst_n) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else if (cpu_tick) begin
      rd_data_o  <= res_q;
      rd_valid_o <= cap_vld;
    end
  end
endmodule

// File: rtl/rf_check.sv
module rf_check #(
  parameter int DW  = 2560,
  parameter int NPH = 5,
  parameter int PW  = 3
)(
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_tick,
  input logic [PW-1:0] phase,
  input logic [DW-1:0] rd_data_o,
  input logic          rd_valid_o
);
  a_r2_realign: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_tick |=> (phase == '0));

  a_r2_tick_slot: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_tick |-> (phase == PW'(NPH - 1)));

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_tick |=> $stable(rd_data_o));

  a_r9_valid_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid_o) |-> $past(cpu_tick));

  a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |=> rd_valid_o);
endmodule

bind phased_regfile rf_check #(.DW(NRD*W), .NPH(NPH), .PW(PW)) u_rf_check (
  .clk(clk_fast), .rst_n(rst_n), .cpu_tick(cpu_tick), .phase(phase),
  .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
);

// File: tb/test_phased_regfile.sv
module test_phased_regfile;
  localparam int W = 128, DEPTH = 64, NWR = 4, NPR = 5, NRPH = 4;
  localparam int AW = $clog2(DEPTH), NRD = NPR * NRPH;
  localparam int NV = 8;
  localparam int VREG  [NV] = '{3, 17, 40, 63, 0, 22, 41, 9};
  localparam int VPORT [NV] = '{0, 1, 2, 3, 3, 2, 1, 0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cnt;
  logic tick;
  logic [NRD*AW-1:0] rd_addr;
  logic [NWR-1:0]    wr_en;
  logic [NWR*AW-1:0] wr_addr;
  logic [NWR*W-1:0]  wr_data;
  logic [NRD*W-1:0]  rd_data;
  logic              rd_valid;
  int errors = 0, checks = 0;
  logic [NRD*W-1:0] snap;

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else cnt <= (cnt == 3'd4) ? 3'd0 : cnt + 3'd1;
  end
  assign tick = (cnt == 3'd4);

  phased_regfile i_phased_regfile (
    .clk_fast(clk), .rst_n(rst_n), .cpu_tick(tick), .rd_addr_i(rd_addr),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  function automatic logic [W-1:0] vdat(int i);
    return {4{32'h1234_0000 + 32'(i) * 32'h0101_0101}};
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] lane(int j);
    return rd_data[j*W +: W];
  endfunction

  task automatic next_tick();
    @(negedge clk);
    while (!tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = '0;
  endtask

  task automatic set_wr(int p, int r, logic [W-1:0] d);
    wr_en[p] = 1'b1;
    wr_addr[p*AW +: AW] = AW'(r);
    wr_data[p*W +: W] = d;
  endtask

  task automatic read_all(int r);
    for (int j = 0; j < NRD; j++) rd_addr[j*AW +: AW] = AW'(r);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rd_addr = '0; wr_en = '0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 valid", W'(rd_valid), W'(0));
    chk("R1 data", lane(0), '0);
    chk("R1 data lane19", lane(NRD - 1), '0);
    rst_n = 1'b1;
    next_tick();
    chk("R9 valid after first tick", W'(rd_valid), W'(0));
    next_tick();
    chk("R9 valid after second tick", W'(rd_valid), W'(1));

    // Vector table: one write per CPU cycle, ports rotating
    for (int i = 0; i < NV; i++) begin
      idle();
      set_wr(VPORT[i], VREG[i], vdat(i));
      next_tick();
    end
    idle();
    for (int j = 0; j < NRD; j++) rd_addr[j*AW +: AW] = AW'(VREG[j % NV]);
    next_tick();
    read_all(VREG[0]);
    next_tick();
    // R2 R3: every lane served in its phase slot with stored data
    for (int j = 0; j < NRD; j++) chk("R2 R3 readback", lane(j), vdat(j % NV));
    snap = rd_data;
    repeat (3) @(negedge clk);
    checks++;
    if (rd_data !== snap) begin
      errors++;
      $display("FAIL R8: actual=%h expected=%h", rd_data[W-1:0], snap[W-1:0]);
    end
    next_tick();
    chk("R3 next published", lane(7), vdat(0));

    // R4: same-cycle bypass on all lanes
    idle();
    set_wr(1, 10, {4{32'hBEEF_0010}});
    read_all(10);
    next_tick();
    idle();
    read_all(0);
    next_tick();
    chk("R4 bypass lane0", lane(0), {4{32'hBEEF_0010}});
    chk("R4 bypass lane19", lane(NRD - 1), {4{32'hBEEF_0010}});
    chk("R4 bypass lane6", lane(6), {4{32'hBEEF_0010}});

    // R5: read in the cycle right after the write
    idle();
    set_wr(2, 11, {4{32'hCAFE_0011}});
    next_tick();
    idle();
    read_all(11);
    next_tick();
    next_tick();
    chk("R5 next-cycle read", lane(3), {4{32'hCAFE_0011}});
    chk("R5 next-cycle read lane16", lane(16), {4{32'hCAFE_0011}});

    // R6: collision of ports 0, 2, 3 on one register
    idle();
    set_wr(0, 12, {4{32'h0000_00A0}});
    set_wr(2, 12, {4{32'h0000_00A2}});
    set_wr(3, 12, {4{32'h0000_00A3}});
    read_all(12);
    next_tick();
    idle();
    next_tick();
    chk("R6 bypass collision", lane(5), {4{32'h0000_00A3}});
    next_tick();
    chk("R6 stored collision", lane(14), {4{32'h0000_00A3}});
    // R6: ports 0 and 1 only
    set_wr(0, 13, {4{32'h0000_00B0}});
    set_wr(1, 13, {4{32'h0000_00B1}});
    read_all(13);
    next_tick();
    idle();
    next_tick();
    next_tick();
    chk("R6 stored pair", lane(9), {4{32'h0000_00B1}});

    // R7: disabled ports with live address and data
    idle();
    for (int p = 0; p < NWR; p++) begin
      wr_addr[p*AW +: AW] = AW'(10);
      wr_data[p*W +: W] = {4{32'hDEAD_DEAD}};
    end
    read_all(10);
    next_tick();
    next_tick();
    chk("R7 disabled same cycle", lane(2), {4{32'hBEEF_0010}});
    next_tick();
    chk("R7 disabled later", lane(18), {4{32'hBEEF_0010}});
    chk("R9 valid stays", W'(rd_valid), W'(1));

    finish_run();
  end
endmodule